// File: doc/BRIEF.md
# Boot-Time Configuration Loader

After reset this block fetches a fixed window of twenty bytes from an external serial EEPROM and writes them, in order, into a small on-chip configuration RAM starting at RAM address zero. The window begins at EEPROM address 0x010, so EEPROM bytes 0x10..0x23 land at RAM 0x00..0x13. Inside the window there are two protected regions. The first is twelve configuration bytes followed by their check byte. The second is six position-offset bytes followed by their check byte. Both check bytes are copied into RAM along with their data.

The block does not produce bit-level bus timing. It drives a byte-level command port on a two-wire (I2C) master that sits beside it. The command set is start, send byte, receive byte with ack or nack, and stop. The master reports completion of each command, a slave nack, and the received byte.

When the transfer ends, the block raises a sticky done flag. Alongside it, it reports one error flag per region, plus a separate flag for an EEPROM that does not answer its address.

Top module: `cfg_boot_loader`

## Requirements
- R1: While reset is held and directly after it, done, cfg_err, ofs_err, nodev_err and ram_we are 0, and the first command offered is a start.
- R2: The command sequence is as follows. It opens with start, then a write of the device byte, then a write of the low eight bits of the window base, then a repeated start, then a write of the device byte with bit 0 set, then 20 reads, then stop. The device byte is 0xA0 with address bits [10:8] of the base placed in bits [3:1], so the default base gives 0xA0 for the write and 0xA1 for the read. The word address byte is 0x10.
- R3: Command codes on cmd_op are 0 = start, 1 = send byte, 2 = receive byte, 3 = stop. A command stays offered, with its code and cmd_wdata unchanged, until cmd_done is sampled high.
- R4: cmd_rd_ack is 1 on each of the first 19 reads and 0 on the 20th.
- R5: Read byte k (k = 0..19) is written once to RAM address k. There are exactly 20 single-cycle strobes, in ascending address order, and each carries the received value.
- R6: cfg_err is set when the modulo-256 sum of window bytes 0..11 differs from window byte 12. The copy still completes.
- R7: ofs_err is set when the modulo-256 sum of window bytes 13..18 differs from window byte 19. The copy still completes.
- R8: If any address or address-byte write is nacked, the loader issues stop and then raises done with nodev_err. In that case no RAM write occurs and cfg_err and ofs_err stay 0.
- R9: done rises only after the stop command completes. done then holds until reset, and no further commands or RAM writes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | output | 1 | A command is offered to the bus master |
| cmd_op | output | 2 | Command code: 0 start, 1 send, 2 receive, 3 stop |
| cmd_wdata | output | 8 | Byte to send for a send command |
| cmd_rd_ack | output | 1 | For a receive command: 1 acknowledge, 0 not acknowledge |
| cmd_done | input | 1 | Master finished the offered command |
| cmd_nack | input | 1 | With cmd_done: the slave did not acknowledge the sent byte |
| cmd_rdata | input | 8 | With cmd_done: byte received |
| ram_we | output | 1 | Configuration RAM write strobe |
| ram_addr | output | 5 | Configuration RAM address |
| ram_wdata | output | 8 | Configuration RAM write data |
| done | output | 1 | Load finished (sticky) |
| cfg_err | output | 1 | Configuration region sum mismatch |
| ofs_err | output | 1 | Offset region sum mismatch |
| nodev_err | output | 1 | EEPROM did not acknowledge; load aborted |

## Verification
A wrong byte counter shows at the ports in two ways. The RAM strobe carries an out-of-order address on the very next write. The master also sees the nack on the wrong receive, or a receive too many or too few, before stop. A corrupted sequencer state shows within one command as a wrong code or a wrong address byte. Faults in the sum accumulators stay hidden until done rises, when the region flags disagree with the sums computed from the EEPROM contents. For that reason the bench runs both good and corrupted check bytes, and runs contents that wrap the sum.

// File: rtl/cbl_pkg.sv
`timescale 1ns/1ps
package cbl_pkg;
   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_SEND  = 2'd1,
      OP_RECV  = 2'd2,
      OP_STOP  = 2'd3
   } cbl_op_e;

   typedef enum logic [2:0] {
      ST_START1, ST_DEVW, ST_WADDR, ST_START2, ST_DEVR, ST_READ, ST_STOP, ST_END
   } cbl_st_e;
endpackage

// File: rtl/cbl_seq.sv
`timescale 1ns/1ps
module cbl_seq
   import cbl_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h50,
   parameter int EE_AW = 11,
   parameter logic [EE_AW-1:0] EE_BASE = 11'h010,
   parameter int TOTAL = 20,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_done,
   input  logic             cmd_nack,
   output logic             cmd_valid,
   output cbl_op_e          cmd_op,
   output logic [7:0]       cmd_wdata,
   output logic             cmd_rd_ack,
   output logic             rd_fire,
   output logic [CNT_W-1:0] rd_idx,
   output logic             fin,
   output logic             aborted
);
   localparam int HI_W = EE_AW - 8;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

   logic [6:0] dev_sel;
   generate
      if (HI_W > 0) begin : g_blk_bits
         assign dev_sel = {DEV_ADDR[6:HI_W], EE_BASE[EE_AW-1:8]};
      end else begin : g_flat
         assign dev_sel = DEV_ADDR;
      end
   endgenerate

   cbl_st_e          st;
   logic [CNT_W-1:0] idx;
   logic             fire;

   assign fire = cmd_valid && cmd_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_START1;
         idx     <= '0;
         aborted <= 1'b0;
      end else if (fire) begin
         case (st)
            ST_START1: st <= ST_DEVW;
            ST_DEVW, ST_WADDR, ST_DEVR: begin
               if (cmd_nack) begin
                  aborted <= 1'b1;
                  st      <= ST_STOP;
               end else if (st == ST_DEVW) begin
                  st <= ST_WADDR;
               end else if (st == ST_WADDR) begin
                  st <= ST_START2;
               end else begin
                  st <= ST_READ;
               end
            end
            ST_START2: st <= ST_DEVR;
            ST_READ: begin
               idx <= idx + 1'b1;
               if (idx == LAST) st <= ST_STOP;
            end
            ST_STOP: st <= ST_END;
            default: st <= ST_END;
         endcase
      end
   end

   always_comb begin
      cmd_valid = (st != ST_END);
      cmd_wdata = 8'h00;
      case (st)
         ST_START1, ST_START2: cmd_op = OP_START;
         ST_DEVW:  begin cmd_op = OP_SEND; cmd_wdata = {dev_sel, 1'b0}; end
         ST_WADDR: begin cmd_op = OP_SEND; cmd_wdata = EE_BASE[7:0]; end
         ST_DEVR:  begin cmd_op = OP_SEND; cmd_wdata = {dev_sel, 1'b1}; end
         ST_READ:  cmd_op = OP_RECV;
         default:  cmd_op = OP_STOP;
      endcase
   end

   assign cmd_rd_ack = (idx != LAST);
   assign rd_fire    = fire && (st == ST_READ);
   assign rd_idx     = idx;
   assign fin        = fire && (st == ST_STOP);
endmodule

// File: rtl/cbl_region_sum.sv
`timescale 1ns/1ps
module cbl_region_sum #(
   parameter int LO    = 0,
   parameter int LEN   = 12,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_vld,
   input  logic [CNT_W-1:0] byte_idx,
   input  logic [7:0]       byte_val,
   output logic             mismatch
);
   localparam logic [CNT_W-1:0] FIRST = CNT_W'(LO);
   localparam logic [CNT_W-1:0] CHK   = CNT_W'(LO + LEN);

   logic [7:0] acc;
   logic [7:0] chk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc <= 8'h00;
         chk <= 8'h00;
      end else if (byte_vld) begin
         if (byte_idx >= FIRST && byte_idx < CHK) acc <= acc + byte_val;
         if (byte_idx == CHK) chk <= byte_val;
      end
   end

   assign mismatch = (acc != chk);
endmodule

// File: rtl/cfg_boot_loader.sv
`timescale 1ns/1ps
module cfg_boot_loader
   import cbl_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h50,
   parameter int EE_AW = 11,
   parameter logic [EE_AW-1:0] EE_BASE = 11'h010,
   parameter int CFG_LEN = 12,
   parameter int OFS_LEN = 6,
   parameter int RAM_AW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              cmd_valid,
   output logic [1:0]        cmd_op,
   output logic [7:0]        cmd_wdata,
   output logic              cmd_rd_ack,
   input  logic              cmd_done,
   input  logic              cmd_nack,
   input  logic [7:0]        cmd_rdata,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [7:0]        ram_wdata,
   output logic              done,
   output logic              cfg_err,
   output logic              ofs_err,
   output logic              nodev_err
);
   localparam int TOTAL   = CFG_LEN + OFS_LEN + 2;
   localparam int CNT_W   = $clog2(TOTAL + 1);
   localparam int NREGION = 2;

   generate
      if (EE_AW < 8 || EE_AW > 11) begin : g_bad_aw
         $error("EE_AW must be within 8..11");
      end
      if (TOTAL > (1 << RAM_AW)) begin : g_bad_ram
         $error("window does not fit the RAM address range");
      end
      if (int'(EE_BASE) + TOTAL > (1 << EE_AW)) begin : g_bad_base
         $error("window runs past the EEPROM address range");
      end
   endgenerate

   cbl_op_e          op;
   logic             rd_fire;
   logic [CNT_W-1:0] rd_idx;
   logic             fin;
   logic             aborted;
   logic [NREGION-1:0] mism;

   cbl_seq #(
      .DEV_ADDR(DEV_ADDR), .EE_AW(EE_AW), .EE_BASE(EE_BASE),
      .TOTAL(TOTAL), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .cmd_nack(cmd_nack),
      .cmd_valid(cmd_valid), .cmd_op(op), .cmd_wdata(cmd_wdata),
      .cmd_rd_ack(cmd_rd_ack), .rd_fire(rd_fire), .rd_idx(rd_idx),
      .fin(fin), .aborted(aborted)
   );

   assign cmd_op = op;

   generate
      for (genvar g = 0; g < NREGION; g++) begin : g_region
         localparam int LO  = (g == 0) ? 0 : CFG_LEN + 1;
         localparam int LEN = (g == 0) ? CFG_LEN : OFS_LEN;
         cbl_region_sum #(.LO(LO), .LEN(LEN), .CNT_W(CNT_W)) u_sum (
            .clk(clk), .rst_n(rst_n), .byte_vld(rd_fire), .byte_idx(rd_idx),
            .byte_val(cmd_rdata), .mismatch(mism[g])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ram_we    <= 1'b0;
         ram_addr  <= '0;
         ram_wdata <= 8'h00;
         done      <= 1'b0;
         cfg_err   <= 1'b0;
         ofs_err   <= 1'b0;
         nodev_err <= 1'b0;
      end else begin
         ram_we <= rd_fire;
         if (rd_fire) begin
            ram_addr  <= RAM_AW'(rd_idx);
            ram_wdata <= cmd_rdata;
         end
         if (fin) begin
            done      <= 1'b1;
            nodev_err <= aborted;
            cfg_err   <= !aborted && mism[0];
            ofs_err   <= !aborted && mism[1];
         end
      end
   end
endmodule

// File: rtl/cbl_checker.sv
`timescale 1ns/1ps
module cbl_checker #(
   parameter int RAM_AW = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [1:0]        cmd_op,
   input logic [7:0]        cmd_wdata,
   input logic              cmd_done,
   input logic              ram_we,
   input logic [RAM_AW-1:0] ram_addr,
   input logic              done,
   input logic              cfg_err,
   input logic              ofs_err,
   input logic              nodev_err
);
   logic [RAM_AW:0] wr_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) wr_cnt <= '0;
      else if (ram_we) wr_cnt <= wr_cnt + 1'b1;
   end

   assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_op) && $stable(cmd_wdata));

   assert_ram_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ({1'b0, ram_addr} == wr_cnt));

   assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !cmd_valid && !ram_we);

   assert_flags_need_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err || ofs_err || nodev_err) |-> done);

   assert_nodev_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
      nodev_err |-> !cfg_err && !ofs_err && (wr_cnt == '0));
endmodule

bind cfg_boot_loader cbl_checker #(.RAM_AW(RAM_AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .ram_we(ram_we),
   .ram_addr(ram_addr), .done(done), .cfg_err(cfg_err), .ofs_err(ofs_err),
   .nodev_err(nodev_err)
);

// File: tb/cfg_boot_loader_bench.sv
`timescale 1ns/1ps
module cfg_boot_loader_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid;
   logic [1:0] cmd_op;
   logic [7:0] cmd_wdata;
   logic       cmd_rd_ack;
   logic       cmd_done = 1'b0;
   logic       cmd_nack = 1'b0;
   logic [7:0] cmd_rdata = 8'h00;
   logic       ram_we;
   logic [4:0] ram_addr;
   logic [7:0] ram_wdata;
   logic       done, cfg_err, ofs_err, nodev_err;

   always #2 clk = ~clk;

   cfg_boot_loader u_cfg_boot_loader (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_wdata(cmd_wdata), .cmd_rd_ack(cmd_rd_ack), .cmd_done(cmd_done),
      .cmd_nack(cmd_nack), .cmd_rdata(cmd_rdata), .ram_we(ram_we),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .done(done),
      .cfg_err(cfg_err), .ofs_err(ofs_err), .nodev_err(nodev_err)
   );

   int n_chk = 0, n_fail = 0, cycles = 0;
   bit timed_out = 0;

   logic [7:0] mem [0:2047];
   logic [7:0] ram_img [0:31];
   bit         present;
   int         phase, lat, n_log, n_rd, n_wr, order_bad, hold_bad;
   logic [2:0] blk;
   logic [10:0] ptr;
   int         op_log [0:63];
   int         dat_log [0:63];
   bit         ack_log [0:31];
   bit         waiting;
   logic [1:0] hold_op;
   logic [7:0] hold_wd;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // behavioural EEPROM behind a byte-level master, plus port monitors
   always @(negedge clk) begin
      cycles++;
      if (!rst_n) begin
         cmd_done = 0;
         cmd_nack = 0;
      end else begin
         if (ram_we) begin
            if (int'(ram_addr) != n_wr) order_bad++;
            ram_img[ram_addr] = ram_wdata;
            n_wr++;
         end
         if (waiting && (cmd_op != hold_op || cmd_wdata != hold_wd)) hold_bad++;
         if (cmd_done) begin
            cmd_done = 0;
            cmd_nack = 0;
         end else if (cmd_valid) begin
            if (lat > 0) lat--;
            else begin
               if (n_log < 64) begin
                  op_log[n_log] = cmd_op;
                  dat_log[n_log] = cmd_wdata;
               end
               n_log++;
               cmd_nack = 0;
               case (cmd_op)
                  2'd0: phase = 1;
                  2'd1: begin
                     if (phase == 1) begin
                        if (!present || cmd_wdata[7:4] != 4'hA) begin
                           cmd_nack = 1;
                           phase = 0;
                        end else begin
                           blk = cmd_wdata[3:1];
                           phase = cmd_wdata[0] ? 3 : 2;
                        end
                     end else if (phase == 2) begin
                        ptr = {blk, cmd_wdata};
                        phase = 0;
                     end else cmd_nack = 1;
                  end
                  2'd2: begin
                     cmd_rdata = mem[ptr];
                     ptr = ptr + 1'b1;
                     if (n_rd < 32) ack_log[n_rd] = cmd_rd_ack;
                     n_rd++;
                  end
                  default: phase = 0;
               endcase
               cmd_done = 1;
               lat = $urandom % 4;
            end
         end
         waiting = cmd_valid && !cmd_done;
         hold_op = cmd_op;
         hold_wd = cmd_wdata;
      end
   end

   function automatic logic [7:0] sum_bytes(input int lo, input int len);
      logic [7:0] s = 8'h00;
      for (int i = 0; i < len; i++) s = s + mem[16 + lo + i];
      return s;
   endfunction

   // fill: 0 random, 1 all zero, 2 all 0xFF (sum wraps)
   task automatic run_case(input bit dev_here, input int fill,
                           input bit bad_cfg, input bit bad_ofs);
      int t;
      bit exp_cfg, exp_ofs;
      for (int a = 0; a < 2048; a++) mem[a] = 8'($urandom);
      for (int a = 16; a < 36; a++)
         mem[a] = (fill == 1) ? 8'h00 : (fill == 2) ? 8'hFF : 8'($urandom);
      mem[16 + 12] = sum_bytes(0, 12);
      mem[16 + 19] = sum_bytes(13, 6);
      if (bad_cfg) mem[16 + 12] = mem[16 + 12] + 8'(1 + $urandom % 255);
      if (bad_ofs) mem[16 + 19] = mem[16 + 19] + 8'(1 + $urandom % 255);
      exp_cfg = dev_here && bad_cfg;
      exp_ofs = dev_here && bad_ofs;

      rst_n = 0;
      present = dev_here;
      phase = 0; lat = 0; n_log = 0; n_rd = 0; n_wr = 0;
      order_bad = 0; hold_bad = 0; waiting = 0; ptr = '0; blk = '0;
      for (int i = 0; i < 32; i++) ram_img[i] = 8'hxx;
      repeat (3) @(negedge clk);
      chk(!done && !cfg_err && !ofs_err && !nodev_err && !ram_we, "R1",
          "flags in reset", {done, cfg_err, ofs_err, nodev_err, ram_we}, 0);
      chk(cmd_valid && cmd_op == 2'd0, "R1", "first command", {cmd_valid, cmd_op}, 4);
      @(posedge clk);
      rst_n = 1;
      t = 0;
      while (!done && t < 3000) begin
         @(negedge clk);
         t++;
      end
      chk(done, "R9", "done reached", done, 1);
      repeat (4) @(negedge clk);
      chk(done && !cmd_valid, "R9", "idle and sticky", {done, cmd_valid}, 2);
      chk(hold_bad == 0, "R3", "command changed before completion", hold_bad, 0);
      chk(nodev_err == !dev_here, "R8", "nodev_err", nodev_err, !dev_here);
      chk(cfg_err == exp_cfg, "R6", "cfg_err", cfg_err, exp_cfg);
      chk(ofs_err == exp_ofs, "R7", "ofs_err", ofs_err, exp_ofs);
      if (!dev_here) begin
         chk(n_log == 3, "R8", "command count", n_log, 3);
         chk(op_log[0] == 0 && op_log[1] == 1 && dat_log[1] == 8'hA0 && op_log[2] == 3,
             "R8", "start/address/stop", op_log[2], 3);
         chk(n_wr == 0, "R8", "RAM writes", n_wr, 0);
      end else begin
         chk(n_log == 26, "R2", "command count", n_log, 26);
         chk(op_log[0] == 0 && op_log[3] == 0 && op_log[25] == 3, "R2",
             "start/restart/stop codes", op_log[25], 3);
         chk(op_log[1] == 1 && dat_log[1] == 8'hA0, "R2", "device write byte", dat_log[1], 8'hA0);
         chk(op_log[2] == 1 && dat_log[2] == 8'h10, "R2", "word address", dat_log[2], 8'h10);
         chk(op_log[4] == 1 && dat_log[4] == 8'hA1, "R2", "device read byte", dat_log[4], 8'hA1);
         chk(n_rd == 20, "R4", "read count", n_rd, 20);
         for (int i = 0; i < 20; i++)
            chk(ack_log[i] == (i != 19), "R4", $sformatf("ack on read %0d", i),
                ack_log[i], i != 19);
         chk(n_wr == 20 && order_bad == 0, "R5", "write count/order", n_wr, 20);
         for (int i = 0; i < 20; i++)
            chk(ram_img[i] === mem[16 + i], "R5", $sformatf("RAM byte %0d", i),
                ram_img[i], mem[16 + i]);
      end
   endtask

   initial begin
      cmd_rdata = 8'h00;
      void'($urandom(32'd4711));
      run_case(1, 0, 0, 0);
      run_case(1, 0, 1, 0);
      run_case(1, 0, 0, 1);
      run_case(1, 0, 1, 1);
      run_case(1, 2, 0, 0);
      run_case(1, 1, 0, 1);
      run_case(0, 0, 0, 0);
      run_case(0, 0, 1, 1);
      for (int k = 0; k < 8; k++)
         run_case(1, 0, 1'($urandom), 1'($urandom));
      run_case(0, 2, 0, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      timed_out = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule